// File: doc/BRIEF.md
# Package Sleep State Sequencer

This block keeps the package-wide low-power state of a two-core processor. Four active-low request pins arrive from the platform: stop-clock, sleep, deep-sleep and deeper-sleep. Each pin commands one step further down a fixed ladder: Normal, Stop-Grant, Sleep, Deep Sleep, Deeper Sleep. When a pin is released, the sequencer climbs back one rung. The pins reach the state register only through a two-flop synchronizer.

The current C-state code of each core caps how far down the package may go. The shallower core sets the limit. A deeper step that the cap forbids is refused: the state holds and a one-cycle flag reports the refusal. The block also reports whether its current state is within the cap.

While the clock is stopped in Stop-Grant, a snoop request parks the package in a snoop-service state until the snoop is reported done. The block then goes back to Stop-Grant. The block holds only the state register, the transition checks and the core-state resolution. Clock gating, voltage control and the snoop logic itself sit outside it.

Top module: `pkg_sleep_seq`

## Requirements
- R1: A synchronous active-low reset places the package in Normal with the refusal flag low.
- R2: A request pin change takes effect at the third rising clock edge after it is driven, through a two-flop synchronizer. Pins read as released while in reset.
- R3: In Normal, an asserted (low) stop-clock pin moves to Stop-Grant. In Stop-Grant, a released stop-clock pin returns to Normal, and this return takes priority over snoop and sleep.
- R4: In Stop-Grant, an asserted sleep pin moves to Sleep. In Sleep, a released sleep pin returns to Stop-Grant.
- R5: In Sleep, an asserted deep-sleep pin moves to Deep Sleep. In Deep Sleep, a released deep-sleep pin returns to Sleep.
- R6: In Deep Sleep, an asserted deeper-sleep pin moves to Deeper Sleep. In Deeper Sleep, a released deeper-sleep pin returns to Deep Sleep.
- R7: In Stop-Grant with stop-clock still asserted, snoop_req moves to Snoop-Service. Snoop-Service ignores every pin and leaves only on snoop_done, back to Stop-Grant.
- R8: Core codes are 0=C0, 1=C1, 2=C2, 3=C3, 4=C4/C6, and codes above 4 count as C4/C6. The cap depth comes from the smaller of the two core codes: C0/C1 gives 0, C2 gives 1, C3 gives 3, C4/C6 gives 4. State depths are Normal 0, Stop-Grant 1, Snoop-Service 1, Sleep 2, Deep Sleep 3, Deeper Sleep 4. target_ok is high exactly when the current state depth is no greater than the cap.
- R9: A deeper step whose destination depth exceeds the cap leaves the state unchanged. illegal_req is then high for one cycle, after the first edge at which the refused request is seen. It is raised again only after an edge with no refused request.
- R10: pkg_state is one-hot with bit 0 Normal, bit 1 Stop-Grant, bit 2 Snoop-Service, bit 3 Sleep, bit 4 Deep Sleep, bit 5 Deeper Sleep.
- R11: The state moves at most one rung per clock, and it holds when no transition condition applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stop_req_n | input | 1 | Stop-clock request, active low, asynchronous |
| sleep_req_n | input | 1 | Sleep request, active low, asynchronous |
| deep_req_n | input | 1 | Deep-sleep request, active low, asynchronous |
| deeper_req_n | input | 1 | Deeper-sleep request, active low, asynchronous |
| snoop_req | input | 1 | Snoop arrival, synchronous |
| snoop_done | input | 1 | Snoop serviced, synchronous |
| core_cst | input | N_CORES*CST_W | Per-core C-state codes, core 0 in the low bits |
| pkg_state | output | 6 | One-hot package state |
| target_ok | output | 1 | Current state is within the core-derived cap |
| illegal_req | output | 1 | One-cycle pulse on a refused deeper request |

## Verification
The bench builds the block with N_CORES=2, CST_W=3 and SYNC_STAGES=2. The 3-bit code width lets core codes 5 to 7 reach the saturation to C4/C6. The two synchronizer stages make the three-edge pin latency something that can be measured. Two cores give cap pairs where either core is the shallower one, so a request can be refused at every rung.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int CST_W    = 3;
  localparam int DEPTH_W  = 3;
  localparam int N_PINS   = 4;
  localparam int N_STATES = 6;

  localparam int PIN_STOP   = 0;
  localparam int PIN_SLEEP  = 1;
  localparam int PIN_DEEP   = 2;
  localparam int PIN_DEEPER = 3;

  typedef enum logic [2:0] {
    PS_NORMAL  = 3'd0,
    PS_STOPGNT = 3'd1,
    PS_SGSNOOP = 3'd2,
    PS_SLEEP   = 3'd3,
    PS_DEEP    = 3'd4,
    PS_DEEPER  = 3'd5
  } pstate_e;

  typedef logic [DEPTH_W-1:0] depth_t;

  // rung depth of each package state
  function automatic depth_t state_depth(input pstate_e s);
    case (s)
      PS_NORMAL:  return depth_t'(0);
      PS_STOPGNT: return depth_t'(1);
      PS_SGSNOOP: return depth_t'(1);
      PS_SLEEP:   return depth_t'(2);
      PS_DEEP:    return depth_t'(3);
      PS_DEEPER:  return depth_t'(4);
      default:    return depth_t'(0);
    endcase
  endfunction

  // deepest package rung a single core code permits
  function automatic depth_t core_depth(input logic [CST_W-1:0] c);
    if (c <= CST_W'(1)) return depth_t'(0);
    if (c == CST_W'(2)) return depth_t'(1);
    if (c == CST_W'(3)) return depth_t'(3);
    return depth_t'(4);
  endfunction

  function automatic logic [N_STATES-1:0] state_onehot(input pstate_e s);
    logic [N_STATES-1:0] v;
    v = '0;
    v[int'(s)] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pss_target.sv
module pss_target
  import pss_pkg::*;
#(
  parameter int N_CORES = 2,
  parameter int CW      = CST_W
) (
  input  logic [N_CORES*CW-1:0] cst_flat,
  output depth_t                tgt_depth
);
  depth_t per_core [N_CORES];

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    assign per_core[g] = core_depth(cst_flat[g*CW +: CW]);
  end

  // the shallowest core bounds the package
  always_comb begin
    tgt_depth = per_core[0];
    for (int i = 1; i < N_CORES; i++) begin
      if (per_core[i] < tgt_depth) tgt_depth = per_core[i];
    end
  end
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_act,
  input  logic              snoop_req,
  input  logic              snoop_done,
  input  depth_t            tgt_depth,
  output pstate_e           st_q,
  output logic              ill_q
);
  pstate_e nxt;
  pstate_e cand;
  logic    want_down;
  logic    blocked;
  logic    blk_q;

  // pick state and any deeper candidate, then gate the candidate with the cap
  always_comb begin
    nxt       = st_q;
    cand      = st_q;
    want_down = 1'b0;
    case (st_q)
      PS_NORMAL: begin
        if (pin_act[PIN_STOP]) begin
          want_down = 1'b1;
          cand      = PS_STOPGNT;
        end
      end
      PS_STOPGNT: begin
        if (!pin_act[PIN_STOP])   nxt = PS_NORMAL;
        else if (snoop_req)       nxt = PS_SGSNOOP;
        else if (pin_act[PIN_SLEEP]) begin
          want_down = 1'b1;
          cand      = PS_SLEEP;
        end
      end
      PS_SGSNOOP: begin
        if (snoop_done) nxt = PS_STOPGNT;
      end
      PS_SLEEP: begin
        if (!pin_act[PIN_SLEEP]) nxt = PS_STOPGNT;
        else if (pin_act[PIN_DEEP]) begin
          want_down = 1'b1;
          cand      = PS_DEEP;
        end
      end
      PS_DEEP: begin
        if (!pin_act[PIN_DEEP]) nxt = PS_SLEEP;
        else if (pin_act[PIN_DEEPER]) begin
          want_down = 1'b1;
          cand      = PS_DEEPER;
        end
      end
      PS_DEEPER: begin
        if (!pin_act[PIN_DEEPER]) nxt = PS_DEEP;
      end
      default: nxt = PS_NORMAL;
    endcase
    blocked = want_down && (state_depth(cand) > tgt_depth);
    if (want_down && !blocked) nxt = cand;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= PS_NORMAL;
      blk_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      st_q  <= nxt;
      blk_q <= blocked;
      ill_q <= blocked && !blk_q;
    end
  end

  // R11: never more than one rung per edge
  p_one_rung_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(state_depth(st_q)) <= int'(state_depth($past(st_q))) + 1) &&
    (int'(state_depth($past(st_q))) <= int'(state_depth(st_q)) + 1));

  // R8: a deeper rung is only reached within the cap seen at that edge
  p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_depth(st_q) > state_depth($past(st_q))) |->
    (state_depth(st_q) <= $past(tgt_depth)));

  // R9: a refusal leaves the state where it was, and lasts one cycle
  p_refuse_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |-> (st_q == $past(st_q)));
  p_refuse_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |=> !ill_q);

  // R7: snoop service holds until done
  p_snoop_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_SGSNOOP && !snoop_done) |=> (st_q == PS_SGSNOOP));

  // R3: stop-clock release always wins in Stop-Grant
  p_stop_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_STOPGNT && !pin_act[PIN_STOP]) |=> (st_q == PS_NORMAL));
endmodule

// File: rtl/pkg_sleep_seq.sv
module pkg_sleep_seq
  import pss_pkg::*;
#(
  parameter int N_CORES     = 2,
  parameter int CW          = CST_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stop_req_n,
  input  logic                  sleep_req_n,
  input  logic                  deep_req_n,
  input  logic                  deeper_req_n,
  input  logic                  snoop_req,
  input  logic                  snoop_done,
  input  logic [N_CORES*CW-1:0] core_cst,
  output logic [N_STATES-1:0]   pkg_state,
  output logic                  target_ok,
  output logic                  illegal_req
);
  logic [N_PINS-1:0] raw_n;
  logic [N_PINS-1:0] sync_n;
  logic [N_PINS-1:0] pin_act;
  depth_t            tgt_depth;
  pstate_e           st_q;

  assign raw_n[PIN_STOP]   = stop_req_n;
  assign raw_n[PIN_SLEEP]  = sleep_req_n;
  assign raw_n[PIN_DEEP]   = deep_req_n;
  assign raw_n[PIN_DEEPER] = deeper_req_n;

  pss_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_n),
    .q    (sync_n)
  );

  assign pin_act = ~sync_n;

  pss_target #(.N_CORES(N_CORES), .CW(CW)) u_target (
    .cst_flat (core_cst),
    .tgt_depth(tgt_depth)
  );

  pss_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_act   (pin_act),
    .snoop_req (snoop_req),
    .snoop_done(snoop_done),
    .tgt_depth (tgt_depth),
    .st_q      (st_q),
    .ill_q     (illegal_req)
  );

  assign pkg_state = state_onehot(st_q);
  assign target_ok = (state_depth(st_q) <= tgt_depth);

  // R10: exactly one state bit at all times after reset
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pkg_state) == 1);

  // R1: the first edge out of reset starts from Normal
  p_reset_normal_r1: assert property (@(posedge clk)
    !rst_n |=> (pkg_state == 6'b000001 && !illegal_req));
endmodule

// File: tb/pkg_sleep_seq_tb_top.sv
`timescale 1ns/1ps
module pkg_sleep_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_req_n = 1'b1, sleep_req_n = 1'b1, deep_req_n = 1'b1, deeper_req_n = 1'b1;
  logic       snoop_req = 1'b0, snoop_done = 1'b0;
  logic [5:0] core_cst = '0;
  logic [5:0] pkg_state;
  logic       target_ok, illegal_req;

  int total = 0, bad = 0;

  // bench model
  int m_st = 0;
  bit m_blk = 0, m_ill = 0;
  logic [3:0] m_s1 = 4'h0, m_s2 = 4'h0;
  string m_tag = "R1";
  int cur_c0 = 0, cur_c1 = 0;

  always #5 clk = ~clk;

  pkg_sleep_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .stop_req_n(stop_req_n), .sleep_req_n(sleep_req_n),
    .deep_req_n(deep_req_n), .deeper_req_n(deeper_req_n),
    .snoop_req(snoop_req), .snoop_done(snoop_done),
    .core_cst(core_cst),
    .pkg_state(pkg_state), .target_ok(target_ok), .illegal_req(illegal_req)
  );

  function automatic int mdepth(int s);
    if (s == 0) return 0;
    if (s <= 2) return 1;
    return s - 1;
  endfunction

  function automatic int mcap(int a, int b);
    int m;
    m = (a < b) ? a : b;
    if (m < 2)  return 0;
    if (m == 2) return 1;
    if (m == 3) return 3;
    return 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int exp_oh;
    exp_oh = 1 << m_st;
    chk(pkg_state == 6'(exp_oh), m_tag, int'(pkg_state), exp_oh);
    chk($countones(pkg_state) == 1, "R10", $countones(pkg_state), 1);
    chk(illegal_req == m_ill, "R9", int'(illegal_req), int'(m_ill));
    chk(target_ok == (mdepth(m_st) <= mcap(cur_c0, cur_c1)), "R8",
        int'(target_ok), int'(mdepth(m_st) <= mcap(cur_c0, cur_c1)));
  endtask

  task automatic model_step(input logic [3:0] pa, input bit sq, input bit sd, input bit rs);
    int tg, nx;
    bit bl, want;
    int want_st;
    if (!rs) begin
      m_st = 0; m_blk = 0; m_ill = 0; m_s1 = 0; m_s2 = 0; m_tag = "R1";
      return;
    end
    tg = mcap(cur_c0, cur_c1);
    nx = m_st; bl = 0; want = 0; want_st = 0; m_tag = "R11";
    case (m_st)
      0: if (m_s2[0]) begin want = 1; want_st = 1; m_tag = "R3"; end
      1: if (!m_s2[0]) begin nx = 0; m_tag = "R3"; end
         else if (sq) begin nx = 2; m_tag = "R7"; end
         else if (m_s2[1]) begin want = 1; want_st = 3; m_tag = "R4"; end
      2: begin m_tag = "R7"; if (sd) nx = 1; end
      3: if (!m_s2[1]) begin nx = 1; m_tag = "R4"; end
         else if (m_s2[2]) begin want = 1; want_st = 4; m_tag = "R5"; end
      4: if (!m_s2[2]) begin nx = 3; m_tag = "R5"; end
         else if (m_s2[3]) begin want = 1; want_st = 5; m_tag = "R6"; end
      default: if (!m_s2[3]) begin nx = 4; m_tag = "R6"; end
    endcase
    if (want) begin
      if (mdepth(want_st) <= tg) nx = want_st;
      else begin bl = 1; m_tag = "R9"; end
    end
    m_ill = bl && !m_blk;
    m_blk = bl;
    m_st  = nx;
    m_s2  = m_s1;
    m_s1  = pa;
  endtask

  // one cycle: check outputs, drive new inputs, advance the model
  task automatic tick(input logic [3:0] pa, input bit sq, input bit sd,
                      input int c0, input int c1, input bit rs);
    @(negedge clk);
    compare();
    rst_n        = rs;
    stop_req_n   = ~pa[0];
    sleep_req_n  = ~pa[1];
    deep_req_n   = ~pa[2];
    deeper_req_n = ~pa[3];
    snoop_req    = sq;
    snoop_done   = sd;
    core_cst     = {3'(c1), 3'(c0)};
    cur_c0 = c0; cur_c1 = c1;
    model_step(pa, sq, sd, rs);
  endtask

  task automatic hold(input int n, input logic [3:0] pa, input int c0, input int c1);
    for (int i = 0; i < n; i++) tick(pa, 0, 0, c0, c1, 1);
  endtask

  function automatic int rcore();
    int r;
    r = $urandom % 10;
    if (r < 2) return r;
    return 2 + ($urandom % 6);
  endfunction

  initial begin
    logic [3:0] pa;
    int c0, c1;
    bit sq, sd, rs;
    void'($urandom(32'd20240611));

    // R1: reset state
    for (int i = 0; i < 3; i++) tick(4'h0, 0, 0, 4, 4, 0);
    chk(pkg_state == 6'b000001, "R1", int'(pkg_state), 1);
    chk(illegal_req == 1'b0, "R1", int'(illegal_req), 0);

    // R2: latency of the stop-clock request
    tick(4'h0, 0, 0, 4, 4, 1);
    tick(4'h1, 0, 0, 4, 4, 1);
    tick(4'h1, 0, 0, 4, 4, 1);
    chk(pkg_state == 6'b000001, "R2", int'(pkg_state), 1);
    tick(4'h1, 0, 0, 4, 4, 1);
    chk(pkg_state == 6'b000001, "R2", int'(pkg_state), 1);
    tick(4'h1, 0, 0, 4, 4, 1);
    chk(pkg_state == 6'b000010, "R2", int'(pkg_state), 2);

    // R4 R5 R6: walk to the bottom with all pins held, then release in reverse
    hold(6, 4'hF, 4, 7);
    chk(pkg_state == 6'b100000, "R6", int'(pkg_state), 32);
    hold(6, 4'h7, 4, 7);
    chk(pkg_state == 6'b010000, "R6", int'(pkg_state), 16);
    hold(6, 4'h3, 4, 7);
    chk(pkg_state == 6'b001000, "R5", int'(pkg_state), 8);
    hold(6, 4'h1, 4, 7);
    chk(pkg_state == 6'b000010, "R4", int'(pkg_state), 2);

    // R9: sleep refused with one core in C2
    tick(4'h3, 0, 0, 2, 4, 1);
    tick(4'h3, 0, 0, 2, 4, 1);
    tick(4'h3, 0, 0, 2, 4, 1);
    tick(4'h3, 0, 0, 2, 4, 1);
    chk(illegal_req == 1'b1, "R9", int'(illegal_req), 1);
    chk(pkg_state == 6'b000010, "R9", int'(pkg_state), 2);
    tick(4'h3, 0, 0, 2, 4, 1);
    chk(illegal_req == 1'b0, "R9", int'(illegal_req), 0);
    chk(target_ok == 1'b1, "R8", int'(target_ok), 1);
    hold(4, 4'h1, 2, 4);

    // R7: snoop service ignores the pins until done
    tick(4'h1, 1, 0, 4, 4, 1);
    tick(4'h0, 0, 0, 4, 4, 1);
    hold(4, 4'h0, 4, 4);
    chk(pkg_state == 6'b000100, "R7", int'(pkg_state), 4);
    tick(4'h0, 0, 1, 4, 4, 1);
    tick(4'h0, 0, 0, 4, 4, 1);
    chk(pkg_state == 6'b000010, "R7", int'(pkg_state), 2);
    tick(4'h0, 0, 0, 4, 4, 1);
    chk(pkg_state == 6'b000001, "R3", int'(pkg_state), 1);

    // R8: C1 in one core while deep drops target_ok
    hold(10, 4'hF, 3, 5);
    chk(pkg_state == 6'b010000, "R8", int'(pkg_state), 16);
    tick(4'hF, 0, 0, 1, 5, 1);
    tick(4'hF, 0, 0, 1, 5, 1);
    chk(target_ok == 1'b0, "R8", int'(target_ok), 0);
    hold(12, 4'h0, 1, 5);

    // random phase, with one reset in the middle
    pa = 4'h0; c0 = 4; c1 = 4;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 5 == 0) pa[$urandom % 4] ^= 1'b1;
      if ($urandom % 25 == 0) c0 = rcore();
      if ($urandom % 25 == 0) c1 = rcore();
      sq = ($urandom % 8 == 0);
      sd = ($urandom % 3 == 0);
      rs = !(i >= 2000 && i < 2002);
      tick(pa, sq, sd, c0, c1, rs);
    end
    @(negedge clk);
    compare();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule